// File: doc/BRIEF.md
# Two-Channel Prescaled Pulse-Width Modulator

This block generates two independent pulse-width modulated outputs from one reference clock, nominally 24 MHz. Software sets up each channel through a small word-addressed register port. One shared control word holds, for each channel, a divider code, a run enable, an output polarity, a clock-gate enable and a clock-forwarding (bypass) switch. A separate period word per channel holds the period length and the number of active ticks.

Each channel divides the reference clock by the ratio its code selects. It then counts the divided ticks through a period and drives its output to the active level for the first part of each period. A period-word update never cuts a running period short. The new value is picked up when the current period wraps. With bypass set, the channel passes the reference clock straight to its pin.

Top module: `pwm2_ctrl`

## Requirements
- R1: Byte offset 0x0 holds the control word, 0x4 the channel 0 period word and 0x8 the channel 1 period word. Address bits [3:2] select the word and bits [1:0] are ignored. A write stores all 32 bits and a read returns the last stored value. A read of offset 0xC returns 0, and a write to 0xC changes nothing. After reset all three words are 0.
- R2: Channel 0's control fields are: divider code in bits [3:0], enable in bit 4, level in bit 5, gate in bit 6 and bypass in bit 9. Channel 1 uses the same fields moved up by 15 bits: code [18:15], enable 19, level 20, gate 21, bypass 24.
- R3: A channel runs only while both its enable and its gate bit are 1. A channel that is not running drives its inactive level, and its tick counter and divider counter restart from zero. Because the reset value of the control word is 0, both outputs are 1 after reset.
- R4: In a period word, bits [31:16] hold the period length in ticks minus one (call it T) and bits [15:0] hold the active tick count A. Counting from the first cycle of running, the output is active during ticks 0 to A-1 of every T+1-tick period. A=0 gives an output that is never active. A of T+1 or more gives an output that is always active.
- R5: The divider codes set the tick length in reference cycles as follows: 15 gives 1, 0 gives 120, 1 gives 180, 2 gives 240, 3 gives 360, 4 gives 480, 8 gives 12000, 9 gives 24000, 10 gives 36000, 11 gives 48000 and 12 gives 72000.
- R6: The codes 5, 6, 7, 13 and 14 are reserved. A running channel with a reserved code stays at its inactive level.
- R7: With the level bit at 1, the active level is high and the inactive level is low. With the level bit at 0, both levels are swapped.
- R8: A period word written while a channel runs takes effect only at the first period wrap after the write. The period that is running when the write arrives completes with the old values.
- R9: With its bypass bit set, a channel's output follows the reference clock, whatever the other fields of that channel hold.
- R10: The two channels are independent. Setting up and running one channel does not change the output of the other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_sel | input | 1 | Register access strobe |
| reg_wr | input | 1 | 1 = write, 0 = read, while reg_sel is high |
| reg_addr | input | 4 | Byte offset of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |
| pwm_out | output | 2 | Channel outputs, bit n = channel n |

## Verification
The hardest case to reach is a period-word update that lands in the middle of a running period. The old period has to finish and the new one has to start exactly at the wrap. The stimulus counts reference cycles from the enable write, places the update at a known cycle inside the second period and computes the cycle of the next wrap to predict the switch point. The large dividers are hard to cover because a single tick lasts thousands of cycles. The stimulus runs one ÷12000 case with a two-tick period and samples cycle by cycle right around the tick edge. Randomly chosen periods, active counts and polarities at ÷1 and ÷120 cover the ordinary waveform shapes.

// File: rtl/pwm2_pkg.sv
`timescale 1ns/1ps
// pwm2_pkg: shared field positions, the per-channel configuration type and
// the divider-code decode for the two-channel modulator.
// Assumes one control word in which channel n's fields sit n*CH_STRIDE bits up.
package pwm2_pkg;

    localparam int DIV_W     = 17;   // wide enough for the largest ratio, 72000
    localparam int F_CODE    = 0;
    localparam int F_EN      = 4;
    localparam int F_LVL     = 5;
    localparam int F_GATE    = 6;
    localparam int F_BYP     = 9;
    localparam int CH_STRIDE = 15;

    typedef struct packed {
        logic [3:0] code;
        logic       en;
        logic       lvl;
        logic       gate;
        logic       byp;
    } ch_cfg_t;

    // Ratio for a divider code; reserved codes return 1.
    function automatic logic [DIV_W-1:0] code_to_div(input logic [3:0] code);
        logic [DIV_W-1:0] r;
        case (code)
            4'd0:    r = DIV_W'(120);
            4'd1:    r = DIV_W'(180);
            4'd2:    r = DIV_W'(240);
            4'd3:    r = DIV_W'(360);
            4'd4:    r = DIV_W'(480);
            4'd8:    r = DIV_W'(12000);
            4'd9:    r = DIV_W'(24000);
            4'd10:   r = DIV_W'(36000);
            4'd11:   r = DIV_W'(48000);
            4'd12:   r = DIV_W'(72000);
            default: r = DIV_W'(1);
        endcase
        return r;
    endfunction

    // True for codes that have no ratio assigned.
    function automatic logic code_reserved(input logic [3:0] code);
        return (code inside {4'd5, 4'd6, 4'd7, 4'd13, 4'd14});
    endfunction

endpackage

// File: rtl/pwm2_regs.sv
`timescale 1ns/1ps
// pwm2_regs: word-addressed register file with one control word and one
// period word per channel. Writes take effect at the clock edge. Reads are
// combinational from the stored words.
// Assumes single-cycle accesses; byte lanes are not supported.
module pwm2_regs #(
    parameter int NUM_CH = 2,
    parameter int DATA_W = 32,
    parameter int ADDR_W = 4
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           sel_i,
    input  logic                           wr_i,
    input  logic [ADDR_W-1:0]              addr_i,
    input  logic [DATA_W-1:0]              wdata_i,
    output logic [DATA_W-1:0]              rdata_o,
    output logic [DATA_W-1:0]              ctrl_o,
    output logic [NUM_CH-1:0][DATA_W-1:0]  period_o
);
    localparam int IDX_W = ADDR_W - 2;

    logic [IDX_W-1:0] idx;
    logic             wr_en;
    logic             unused_addr_lsb;

    assign idx             = addr_i[ADDR_W-1:2];
    assign wr_en           = sel_i && wr_i;
    assign unused_addr_lsb = ^addr_i[1:0];

    // Control word storage.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ctrl_o <= '0;
        else if (wr_en && idx == '0)
            ctrl_o <= wdata_i;
    end

    // One period word per channel, at word index channel+1.
    for (genvar g = 0; g < NUM_CH; g++) begin : g_period
        always_ff @(posedge clk) begin
            if (!rst_n)
                period_o[g] <= '0;
            else if (wr_en && idx == IDX_W'(g + 1))
                period_o[g] <= wdata_i;
        end
    end

    // Read multiplexer; unmapped words read 0.
    always_comb begin
        rdata_o = '0;
        if (idx == '0)
            rdata_o = ctrl_o;
        for (int c = 0; c < NUM_CH; c++)
            if (idx == IDX_W'(c + 1))
                rdata_o = period_o[c];
    end

    p_ctrl_write_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && idx == '0) |=> (ctrl_o == $past(wdata_i)));

    p_ctrl_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && idx == '0) |=> $stable(ctrl_o));

endmodule

// File: rtl/pwm2_prescaler.sv
`timescale 1ns/1ps
// pwm2_prescaler: divides the reference clock by div_i and gives a one-cycle
// tick in the last reference cycle of every divided interval.
// Assumes div_i >= 1. While run_i is low the counter is held at zero.
module pwm2_prescaler
    import pwm2_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic [DIV_W-1:0] div_i,
    output logic             tick_o
);
    logic [DIV_W-1:0] pcnt_q;
    logic             at_end;

    assign at_end = (pcnt_q >= div_i - 1'b1);
    assign tick_o = run_i && (pcnt_q == div_i - 1'b1);

    // Reference-cycle counter inside one divided interval.
    always_ff @(posedge clk) begin
        if (!rst_n || !run_i)
            pcnt_q <= '0;
        else if (at_end)
            pcnt_q <= '0;
        else
            pcnt_q <= pcnt_q + 1'b1;
    end

    p_idle_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(run_i) |-> (pcnt_q == '0));

    p_tick_spacing_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_o && div_i > 1 && run_i) |=> (!tick_o || div_i == 1));

endmodule

// File: rtl/pwm2_channel.sv
`timescale 1ns/1ps
// pwm2_channel: one modulator channel. It holds a working copy of its period
// word that reloads only at a period wrap, counts divided ticks through the
// period and drives the output. A polarity select sets the output level and
// a clock-forwarding mux can replace the waveform with the reference clock.
// Assumes the period word splits into two CNT_W halves: length-1, active.
module pwm2_channel
    import pwm2_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  ch_cfg_t            cfg_i,
    input  logic [2*CNT_W-1:0] period_i,
    output logic               pwm_o
);
    logic             run;
    logic             reserved;
    logic [DIV_W-1:0] div;
    logic             tick;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] tot_q;
    logic [CNT_W-1:0] act_q;
    logic             wrap;
    logic             in_active;
    logic             wave;

    assign run      = cfg_i.en && cfg_i.gate;
    assign reserved = code_reserved(cfg_i.code);
    assign div      = reserved ? DIV_W'(1) : code_to_div(cfg_i.code);
    assign wrap     = tick && (cnt_q == tot_q);

    pwm2_prescaler u_presc (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_i  (run),
        .div_i  (div),
        .tick_o (tick)
    );

    // Tick counter and working period copy; the copy follows the register
    // while idle and reloads only at a wrap while running.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            tot_q <= '0;
            act_q <= '0;
        end else if (!run) begin
            cnt_q <= '0;
            tot_q <= period_i[2*CNT_W-1:CNT_W];
            act_q <= period_i[CNT_W-1:0];
        end else if (wrap) begin
            cnt_q <= '0;
            tot_q <= period_i[2*CNT_W-1:CNT_W];
            act_q <= period_i[CNT_W-1:0];
        end else if (tick) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // Active phase, polarity and clock forwarding.
    always_comb begin
        in_active = run && !reserved && (cnt_q < act_q);
        wave      = in_active ? cfg_i.lvl : !cfg_i.lvl;
        pwm_o     = cfg_i.byp ? clk : wave;
    end

    p_cnt_in_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= tot_q);

    p_idle_inactive_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !cfg_i.byp) |-> (pwm_o == !cfg_i.lvl));

    p_reserved_inactive_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (run && reserved && !cfg_i.byp) |-> (pwm_o == !cfg_i.lvl));

    p_reload_at_wrap_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(run) && run && !$past(wrap)) |-> ($stable(tot_q) && $stable(act_q)));

endmodule

// File: rtl/pwm2_ctrl.sv
`timescale 1ns/1ps
// pwm2_ctrl: top of the two-channel modulator. It splits the shared control
// word into per-channel fields and instantiates the register file and one
// channel per output.
// Assumes the reference clock is clk and all register accesses use it.
module pwm2_ctrl
    import pwm2_pkg::*;
#(
    parameter int NUM_CH = 2,
    parameter int DATA_W = 32,
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_sel,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic [NUM_CH-1:0] pwm_out
);
    localparam int CNT_W = DATA_W / 2;

    logic [DATA_W-1:0]             ctrl;
    logic [NUM_CH-1:0][DATA_W-1:0] period;
    ch_cfg_t [NUM_CH-1:0]          cfg;
    logic                          unused_ctrl_bits;

    assign unused_ctrl_bits = ^ctrl;

    pwm2_regs #(
        .NUM_CH (NUM_CH),
        .DATA_W (DATA_W),
        .ADDR_W (ADDR_W)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .sel_i    (reg_sel),
        .wr_i     (reg_wr),
        .addr_i   (reg_addr),
        .wdata_i  (reg_wdata),
        .rdata_o  (reg_rdata),
        .ctrl_o   (ctrl),
        .period_o (period)
    );

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        localparam int B = g * CH_STRIDE;

        // Field extraction for channel g from the shared control word.
        always_comb begin
            cfg[g].code = ctrl[B + F_CODE +: 4];
            cfg[g].en   = ctrl[B + F_EN];
            cfg[g].lvl  = ctrl[B + F_LVL];
            cfg[g].gate = ctrl[B + F_GATE];
            cfg[g].byp  = ctrl[B + F_BYP];
        end

        pwm2_channel #(
            .CNT_W (CNT_W)
        ) u_ch (
            .clk      (clk),
            .rst_n    (rst_n),
            .cfg_i    (cfg[g]),
            .period_i (period[g]),
            .pwm_o    (pwm_out[g])
        );
    end

endmodule

// File: tb/pwm2_ctrl_tb_top.sv
`timescale 1ns/1ps
module pwm2_ctrl_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_sel = 1'b0;
    logic        reg_wr = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [1:0]  pwm_out;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    // Expectation state for the channel under test.
    int   cur_ch, cur_d, cur_p, cur_a, nxt_p, nxt_a, sw_k;
    logic cur_lvl;
    bit   cur_res;

    always #4 clk = ~clk;

    pwm2_ctrl dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_sel   (reg_sel),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .pwm_out   (pwm_out)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_sel = 1'b1; reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk);
        #1;
        reg_sel = 1'b0; reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_sel = 1'b1; reg_wr = 1'b0; reg_addr = a;
        #1;
        d = reg_rdata;
        reg_sel = 1'b0;
    endtask

    // Control word fields per R2.
    function automatic logic [31:0] mk_ctrl(int ch, int code, bit en, bit lvl, bit gate, bit byp);
        logic [31:0] w;
        w = '0;
        w[3:0] = code[3:0];
        w[4] = en; w[5] = lvl; w[6] = gate; w[9] = byp;
        return w << (15 * ch);
    endfunction

    function automatic int code_ratio(int code);
        case (code)
            0: return 120;   1: return 180;   2: return 240;   3: return 360;
            4: return 480;   8: return 12000; 9: return 24000; 10: return 36000;
            11: return 48000; 12: return 72000;
            default: return 1;
        endcase
    endfunction

    // Expected output in cycle k after the enable write (R4, R5, R6, R7, R8).
    function automatic logic exp_wave(int k);
        int kk, p, a, t;
        if (k >= sw_k) begin kk = k - sw_k; p = nxt_p; a = nxt_a; end
        else begin kk = k; p = cur_p; a = cur_a; end
        if (cur_res) return ~cur_lvl;
        t = (kk / cur_d) % p;
        return (t < a) ? cur_lvl : ~cur_lvl;
    endfunction

    task automatic run_span(input string req, input int k0, input int n, input int step);
        for (int k = k0; k < k0 + n; k++) begin
            #1;
            if (((k - k0) % step) == 0)
                chk(req, {31'd0, pwm_out[cur_ch]}, {31'd0, exp_wave(k)});
            @(posedge clk);
            #1;
        end
    endtask

    task automatic start_ch(input int ch, input int code, input bit lvl, input int tot, input int act);
        wr(4'(4 * (ch + 1)), {tot[15:0], act[15:0]});
        cur_ch = ch; cur_d = code_ratio(code); cur_p = tot + 1; cur_a = act;
        cur_lvl = lvl; sw_k = 1 << 30;
        cur_res = (code inside {5, 6, 7, 13, 14});
        wr(4'h0, mk_ctrl(ch, code, 1, lvl, 1, 0));
    endtask

    task automatic stop_all();
        wr(4'h0, 32'h0);
        #1;
        chk("R3 idle after disable", {30'd0, pwm_out}, 32'd3);
    endtask

    initial begin
        #(8 * 190000);
        n_fail++;
        $display("FAIL watchdog: actual running expected finished");
        if (!done) begin
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        void'($urandom(32'd20240611));
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;

        // Reset state (R1, R3)
        rd(4'h0, d); chk("R1 reset ctrl", d, 32'h0);
        rd(4'h4, d); chk("R1 reset period0", d, 32'h0);
        #1 chk("R3 reset outputs", {30'd0, pwm_out}, 32'd3);

        // Register readback and unmapped word (R1)
        wr(4'h4, 32'hDEAD_BEEF);
        wr(4'h8, 32'h1234_5678);
        wr(4'h0, 32'h8001_0000);
        wr(4'hC, 32'hFFFF_FFFF);
        rd(4'h4, d); chk("R1 period0 readback", d, 32'hDEAD_BEEF);
        rd(4'h8, d); chk("R1 period1 readback", d, 32'h1234_5678);
        rd(4'h0, d); chk("R1 ctrl readback", d, 32'h8001_0000);
        rd(4'hC, d); chk("R1 unmapped read", d, 32'h0);
        rd(4'h6, d); chk("R1 low address bits ignored", d, 32'hDEAD_BEEF);
        stop_all();

        // Enable alone and gate alone keep the output inactive (R3)
        wr(4'h4, {16'd3, 16'd9});
        wr(4'h0, mk_ctrl(0, 15, 1, 1, 0, 0));
        repeat (3) begin #1 chk("R3 enable only", {31'd0, pwm_out[0]}, 32'd0); @(posedge clk); #1; end
        wr(4'h0, mk_ctrl(0, 15, 0, 1, 1, 0));
        repeat (3) begin #1 chk("R3 gate only", {31'd0, pwm_out[0]}, 32'd0); @(posedge clk); #1; end
        stop_all();

        // Basic waveform at divide-by-1, both polarities (R4, R5, R7)
        start_ch(0, 15, 1, 4, 2); run_span("R4 basic high", 0, 20, 1); stop_all();
        start_ch(0, 15, 0, 4, 2); run_span("R7 inverted", 0, 20, 1); stop_all();
        // Zero active and overlong active (R4)
        start_ch(0, 15, 1, 4, 0); run_span("R4 active zero", 0, 12, 1); stop_all();
        start_ch(0, 15, 1, 4, 7); run_span("R4 active over period", 0, 12, 1); stop_all();
        start_ch(0, 15, 1, 4, 5); run_span("R4 active equals period", 0, 12, 1); stop_all();

        // Divider ratios (R5)
        start_ch(0, 0, 1, 2, 1); run_span("R5 div120", 0, 720, 1); stop_all();
        start_ch(0, 1, 1, 1, 1); run_span("R5 div180", 0, 400, 1); stop_all();
        start_ch(0, 8, 1, 1, 1);
        run_span("R5 div12000", 0, 11996, 2999);
        run_span("R5 div12000 edge", 11996, 8, 1);
        stop_all();

        // Reserved codes (R6)
        start_ch(0, 5, 1, 3, 9); run_span("R6 reserved 5", 0, 10, 1); stop_all();
        start_ch(0, 14, 0, 3, 9); run_span("R6 reserved 14", 0, 10, 1); stop_all();

        // Period word update mid-period (R8): lands in cycle 10, wrap at 12
        start_ch(0, 15, 1, 5, 3);
        run_span("R8 before update", 0, 9, 1);
        wr(4'h4, {16'd2, 16'd1});
        nxt_p = 3; nxt_a = 1; sw_k = 12;
        run_span("R8 across update", 10, 24, 1);
        stop_all();

        // Channel 1 fields and independence (R2, R10)
        start_ch(1, 15, 1, 3, 1);
        for (int k = 0; k < 16; k++) begin
            #1;
            chk("R2 channel1 wave", {31'd0, pwm_out[1]}, {31'd0, exp_wave(k)});
            chk("R10 channel0 untouched", {31'd0, pwm_out[0]}, 32'd1);
            @(posedge clk); #1;
        end
        stop_all();

        // Bypass forwards the reference clock (R9)
        wr(4'h0, mk_ctrl(0, 3, 0, 0, 0, 1) | mk_ctrl(1, 15, 1, 1, 1, 1));
        repeat (3) begin
            #1 chk("R9 bypass high phase", {30'd0, pwm_out}, 32'd3);
            #4 chk("R9 bypass low phase", {30'd0, pwm_out}, 32'd0);
            @(posedge clk); #1;
        end
        stop_all();

        // Random waveforms (R4, R5, R7)
        for (int it = 0; it < 8; it++) begin
            int code, tot, act, step;
            bit lvl;
            code = ($urandom % 2) ? 15 : 0;
            tot  = $urandom % 8;
            act  = $urandom % 10;
            lvl  = 1'($urandom % 2);
            step = (code == 15) ? 1 : 7;
            start_ch(it % 2, code, lvl, tot, act);
            run_span("R4 random", 0, 2 * (tot + 1) * code_ratio(code), step);
            stop_all();
        end

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule